// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block holds the transmit and receive byte queues of a serial peripheral controller and reports their state. Each queue holds up to 32 bytes. Software pushes transmit data as 32-bit words, and the serial shifter takes it out one byte at a time. The shifter pushes receive bytes one at a time. Software drains them either as a 32-bit word or one byte at a time, so a trailing group of fewer than four bytes can still be collected.

A small register port gives access to three registers. The first is a mode register holding the two threshold levels. The second is an event register with the live byte counts of both queues, four live status flags and three sticky flags. Writing a 1 to a sticky flag clears it. The third is a mask register with the same bit layout as the event register. A single level interrupt is raised whenever an event bit and its mask bit are both set.

Top module: `spi_fifo_evt`

## Requirements
- R1: While and after `rst`, both queues are empty, all sticky flags and the mask are 0, the event register reads 0x0000_8100 and `irq` is 0.
- R2: The event register carries the receive byte count in bits 29:24 and the transmit byte count in bits 21:16. All bits not named in R2–R6 read 0.
- R3: The live flags follow the queues each cycle. Bit 15 is set when the transmit count is 0. Bit 8 is set when the transmit count is at most 28 (room for a word). Bit 12 is set when the receive count is 32. Bit 9 is set when the receive count is non-zero.
- R4: Bit 14 (transfer done) sets on an `xfer_done` pulse and stays set until cleared.
- R5: Bit 13 sets sticky in the cycle the receive count goes from not above the receive threshold to above it.
- R6: Bit 11 sets sticky in the cycle the transmit count goes from not below the transmit threshold to below it.
- R7: A write to the event register (address 1) clears each sticky bit (14, 13, 11) written as 1. Bits written as 0, and the live bits, are unaffected. A set in the same cycle wins over the clear.
- R8: The mask register (address 2) stores only bits 15:11 and 9:8 of the written value and reads back the same. `irq` equals the OR of (event AND mask).
- R9: The mode register (address 0) holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. It reads 0x0000_0403 after reset (transmit 4, receive 3). Other bits read 0.
- R10: `tx_push` enqueues `tx_wdata` as four bytes, bits 31:24 first. `tx_byte` shows the oldest byte and `tx_pop` removes it. A push with fewer than 4 free bytes is ignored, as is a pop of an empty queue.
- R11: `rx_word` shows the four oldest receive bytes, the oldest in bits 31:24. `rx_pop_word` removes four bytes and takes priority over `rx_pop_byte`. It is ignored, with nothing removed, when fewer than 4 bytes are held.
- R12: `rx_pop_byte` removes one byte (shown in `rx_word[31:24]`) and is ignored when the queue is empty. `rx_push` appends `rx_byte` and is ignored when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Enqueue a transmit word |
| tx_wdata | input | 32 | Transmit word, first byte in 31:24 |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter appends a receive byte |
| rx_byte | input | 8 | Receive byte to append |
| rx_pop_word | input | 1 | Remove four receive bytes |
| rx_pop_byte | input | 1 | Remove one receive byte |
| rx_word | output | 32 | Four oldest receive bytes, oldest in 31:24 |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 mode, 1 event, 2 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
Any push, pop, done pulse or register write presented before a rising edge takes effect at that edge. The counts, live flags, sticky flags, queue heads, register read data and `irq` all show the new state in the same cycle after that edge, because the threshold crossing is computed from the next-state counts. The bench therefore drives stimulus just after a falling edge. It compares every output at the following falling edge against a reference model, which is advanced once per driven cycle from the requirements. The register read data is sampled a short delay after `reg_addr` changes within that half cycle.

// File: rtl/spi_fevt_pkg.sv
package spi_fevt_pkg;

    localparam int THR_W = 6;

    // event bit positions (shared by mask register)
    localparam int B_TXE = 15;
    localparam int B_DON = 14;
    localparam int B_RXT = 13;
    localparam int B_RXF = 12;
    localparam int B_TXT = 11;
    localparam int B_RNE = 9;
    localparam int B_TNF = 8;

    localparam logic [31:0] FLAG_BITS = 32'h0000_FB00;

    typedef enum logic [1:0] {
        A_MODE = 2'd0,
        A_EVT  = 2'd1,
        A_MASK = 2'd2,
        A_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic txe;
        logic don;
        logic rxt;
        logic rxf;
        logic txt;
        logic rne;
        logic tnf;
    } flags_t;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
    } mode_t;

    function automatic logic [31:0] pack_event(input logic [5:0] rxc,
                                               input logic [5:0] txc,
                                               input flags_t f);
        logic [31:0] v;
        v = '0;
        v[29:24] = rxc;
        v[21:16] = txc;
        v[B_TXE] = f.txe;
        v[B_DON] = f.don;
        v[B_RXT] = f.rxt;
        v[B_RXF] = f.rxf;
        v[B_TXT] = f.txt;
        v[B_RNE] = f.rne;
        v[B_TNF] = f.tnf;
        return v;
    endfunction

    function automatic logic [31:0] pack_mode(input mode_t m);
        logic [31:0] v;
        v = '0;
        v[8 +: THR_W] = m.tx_thr;
        v[0 +: THR_W] = m.rx_thr;
        return v;
    endfunction

endpackage

// File: rtl/sfe_byte_fifo.sv
module sfe_byte_fifo #(
    parameter int DEPTH      = 32,
    parameter int HEAD_BYTES = 4,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push_word,
    input  logic                    push_byte,
    input  logic [31:0]             wdata,
    input  logic                    pop_word,
    input  logic                    pop_byte,
    output logic [8*HEAD_BYTES-1:0] head,
    output logic [CNT_W-1:0]        count,
    output logic [CNT_W-1:0]        count_nxt
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pw, do_pb, do_ow, do_ob;
    logic [2:0]       push_n, pop_n;

    assign do_pw = push_word && (cnt_q <= CNT_W'(DEPTH - 4));
    assign do_pb = push_byte && !push_word && (cnt_q != CNT_W'(DEPTH));
    assign do_ow = pop_word && (cnt_q >= CNT_W'(4));
    assign do_ob = pop_byte && !pop_word && (cnt_q != '0);

    assign push_n = do_pw ? 3'd4 : (do_pb ? 3'd1 : 3'd0);
    assign pop_n  = do_ow ? 3'd4 : (do_ob ? 3'd1 : 3'd0);

    assign count     = cnt_q;
    assign count_nxt = cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            cnt_q  <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (do_pw) begin
                for (int k = 0; k < 4; k++)
                    mem[wr_ptr + PTR_W'(k)] <= wdata[31-8*k -: 8];
            end else if (do_pb) begin
                mem[wr_ptr] <= wdata[7:0];
            end
        end
    end

    for (genvar g = 0; g < HEAD_BYTES; g++) begin : g_head
        assign head[8*HEAD_BYTES-1-8*g -: 8] = mem[rd_ptr + PTR_W'(g)];
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_byte && !pop_word && cnt_q == '0 && !push_word && !push_byte)
        |=> (cnt_q == '0));

endmodule

// File: rtl/sfe_event_ctl.sv
module sfe_event_ctl
    import spi_fevt_pkg::*;
#(
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] tx_cnt_nxt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] rx_cnt_nxt,
    input  mode_t            mode,
    input  logic             done_in,
    input  logic             clr_en,
    input  logic [2:0]       clr_bits,   // {don, rxt, txt}
    input  logic [31:0]      mask,
    output logic [31:0]      evt_word,
    output logic             irq
);
    logic   don_q, rxt_q, txt_q;
    logic   rxt_set, txt_set;
    logic   clr_don, clr_rxt, clr_txt;
    flags_t fl;

    assign rxt_set = (int'(rx_cnt_nxt) > int'(mode.rx_thr)) &&
                     !(int'(rx_cnt) > int'(mode.rx_thr));
    assign txt_set = (int'(tx_cnt_nxt) < int'(mode.tx_thr)) &&
                     !(int'(tx_cnt) < int'(mode.tx_thr));

    assign clr_don = clr_en && clr_bits[2];
    assign clr_rxt = clr_en && clr_bits[1];
    assign clr_txt = clr_en && clr_bits[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            don_q <= 1'b0;
            rxt_q <= 1'b0;
            txt_q <= 1'b0;
        end else begin
            don_q <= done_in | (don_q & ~clr_don);
            rxt_q <= rxt_set | (rxt_q & ~clr_rxt);
            txt_q <= txt_set | (txt_q & ~clr_txt);
        end
    end

    always_comb begin
        fl.txe = (tx_cnt == '0);
        fl.don = don_q;
        fl.rxt = rxt_q;
        fl.rxf = (rx_cnt == CNT_W'(DEPTH));
        fl.txt = txt_q;
        fl.rne = (rx_cnt != '0);
        fl.tnf = (tx_cnt <= CNT_W'(DEPTH - 4));
    end

    assign evt_word = pack_event(6'(rx_cnt), 6'(tx_cnt), fl);
    assign irq      = |(evt_word & mask);

    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        done_in |=> don_q);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_don && !done_in) |=> !don_q);

    // R5
    rxt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rxt_q && !clr_rxt) |=> rxt_q);

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
    import spi_fevt_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int TX_THR_INIT = 4,
    parameter int RX_THR_INIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_push,
    input  logic [31:0] tx_wdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        rx_pop_word,
    input  logic        rx_pop_byte,
    output logic [31:0] rx_word,
    input  logic        xfer_done,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
    mode_t            mode_q;
    logic [31:0]      mask_q;
    logic [31:0]      evt_word;
    reg_sel_e         sel;
    logic             evt_wr;

    assign sel    = reg_sel_e'(reg_addr);
    assign evt_wr = reg_we && (sel == A_EVT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.tx_thr <= THR_W'(TX_THR_INIT);
            mode_q.rx_thr <= THR_W'(RX_THR_INIT);
            mask_q        <= '0;
        end else if (reg_we) begin
            if (sel == A_MODE) begin
                mode_q.tx_thr <= reg_wdata[8 +: THR_W];
                mode_q.rx_thr <= reg_wdata[0 +: THR_W];
            end
            if (sel == A_MASK)
                mask_q <= reg_wdata & FLAG_BITS;
        end
    end

    always_comb begin
        case (sel)
            A_MODE:  reg_rdata = pack_mode(mode_q);
            A_EVT:   reg_rdata = evt_word;
            A_MASK:  reg_rdata = mask_q;
            default: reg_rdata = '0;
        endcase
    end

    sfe_byte_fifo #(.DEPTH(DEPTH), .HEAD_BYTES(1)) u_txq (
        .clk(clk), .rst(rst),
        .push_word(tx_push), .push_byte(1'b0), .wdata(tx_wdata),
        .pop_word(1'b0), .pop_byte(tx_pop),
        .head(tx_byte), .count(tx_cnt), .count_nxt(tx_cnt_nxt)
    );

    sfe_byte_fifo #(.DEPTH(DEPTH), .HEAD_BYTES(4)) u_rxq (
        .clk(clk), .rst(rst),
        .push_word(1'b0), .push_byte(rx_push), .wdata({24'd0, rx_byte}),
        .pop_word(rx_pop_word), .pop_byte(rx_pop_byte),
        .head(rx_word), .count(rx_cnt), .count_nxt(rx_cnt_nxt)
    );

    sfe_event_ctl #(.DEPTH(DEPTH)) u_evt (
        .clk(clk), .rst(rst),
        .tx_cnt(tx_cnt), .tx_cnt_nxt(tx_cnt_nxt),
        .rx_cnt(rx_cnt), .rx_cnt_nxt(rx_cnt_nxt),
        .mode(mode_q), .done_in(xfer_done),
        .clr_en(evt_wr),
        .clr_bits({reg_wdata[B_DON], reg_wdata[B_RXT], reg_wdata[B_TXT]}),
        .mask(mask_q), .evt_word(evt_word), .irq(irq)
    );

    // R6
    txt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_word[B_TXT] && !(evt_wr && reg_wdata[B_TXT])) |=> evt_word[B_TXT]);

endmodule

// File: tb/tb_spi_fifo_evt.sv
`timescale 1ns/1ps
module tb_spi_fifo_evt;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        tx_push, tx_pop, rx_push, rx_pop_word, rx_pop_byte, xfer_done, reg_we;
    logic [31:0] tx_wdata, reg_wdata, rx_word, reg_rdata;
    logic [7:0]  tx_byte, rx_byte;
    logic [1:0]  reg_addr;
    logic        irq;

    spi_fifo_evt dut (
        .clk(clk), .rst(rst),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_pop_word(rx_pop_word),
        .rx_pop_byte(rx_pop_byte), .rx_word(rx_word), .xfer_done(xfer_done),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    byte unsigned txq[$];
    byte unsigned rxq[$];
    logic        don_e, rxt_e, txt_e;
    int          tthr, rthr;
    logic [31:0] mask_e;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done_run = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_evt();
        logic [31:0] v;
        int t, r;
        t = txq.size();
        r = rxq.size();
        v = '0;
        v[29:24] = 6'(r);
        v[21:16] = 6'(t);
        v[15] = (t == 0);
        v[14] = don_e;
        v[13] = rxt_e;
        v[12] = (r == DEPTH);
        v[11] = txt_e;
        v[9]  = (r != 0);
        v[8]  = (t <= DEPTH - 4);
        return v;
    endfunction

    task automatic idle();
        tx_push = 0; tx_wdata = '0; tx_pop = 0; rx_push = 0; rx_byte = '0;
        rx_pop_word = 0; rx_pop_byte = 0; xfer_done = 0; reg_we = 0;
        reg_addr = 2'd1; reg_wdata = '0;
    endtask

    task automatic check_all();
        logic [31:0] ev, mode_e, w;
        ev = exp_evt();
        reg_addr = 2'd1; #0.2;
        chk("R2 counts", reg_rdata & 32'h3F3F_0000, ev & 32'h3F3F_0000);
        chk("R2 zero bits", reg_rdata & 32'hC0C0_04FF, 32'h0);
        chk("R3 live flags", reg_rdata & 32'h0000_9300, ev & 32'h0000_9300);
        chk("R4 done flag", 32'(reg_rdata[14]), 32'(ev[14]));
        chk("R5 rx threshold flag", 32'(reg_rdata[13]), 32'(ev[13]));
        chk("R6 tx threshold flag", 32'(reg_rdata[11]), 32'(ev[11]));
        chk("R8 irq", 32'(irq), 32'(|(ev & mask_e)));
        reg_addr = 2'd2; #0.2;
        chk("R8 mask readback", reg_rdata, mask_e);
        reg_addr = 2'd0; #0.2;
        mode_e = '0; mode_e[13:8] = 6'(tthr); mode_e[5:0] = 6'(rthr);
        chk("R9 mode readback", reg_rdata, mode_e);
        reg_addr = 2'd3; #0.2;
        chk("R9 unused address", reg_rdata, 32'h0);
        if (txq.size() > 0) chk("R10 tx head", 32'(tx_byte), 32'(txq[0]));
        if (rxq.size() >= 4) begin
            w = {rxq[0], rxq[1], rxq[2], rxq[3]};
            chk("R11 rx word", rx_word, w);
        end else if (rxq.size() >= 1) begin
            chk("R12 rx head byte", 32'(rx_word[31:24]), 32'(rxq[0]));
        end
        reg_addr = 2'd1;
    endtask

    // Drive one cycle of stimulus, advance the model, check after the edge
    task automatic cycle(input bit tp, input logic [31:0] tw, input bit tq,
                         input bit rp, input logic [7:0] rb, input bit rw, input bit rbp,
                         input bit dn, input bit we, input logic [1:0] a, input logic [31:0] wd);
        int t0, r0, t1, r1;
        logic [31:0] clr;
        bit rs, ts;
        tx_push = tp; tx_wdata = tw; tx_pop = tq; rx_push = rp; rx_byte = rb;
        rx_pop_word = rw; rx_pop_byte = rbp; xfer_done = dn; reg_we = we;
        reg_addr = a; reg_wdata = wd;
        t0 = txq.size(); r0 = rxq.size();
        if (tq && t0 > 0) void'(txq.pop_front());
        if (tp && t0 <= DEPTH - 4)
            for (int k = 0; k < 4; k++) txq.push_back(tw[31-8*k -: 8]);
        if (rw) begin
            if (r0 >= 4) for (int k = 0; k < 4; k++) void'(rxq.pop_front());
        end else if (rbp && r0 > 0) void'(rxq.pop_front());
        if (rp && r0 < DEPTH) rxq.push_back(rb);
        t1 = txq.size(); r1 = rxq.size();
        rs = (r1 > rthr) && !(r0 > rthr);
        ts = (t1 < tthr) && !(t0 < tthr);
        clr = (we && a == 2'd1) ? wd : 32'h0;
        don_e = dn | (don_e & ~clr[14]);
        rxt_e = rs | (rxt_e & ~clr[13]);
        txt_e = ts | (txt_e & ~clr[11]);
        if (we && a == 2'd0) begin tthr = int'(wd[13:8]); rthr = int'(wd[5:0]); end
        if (we && a == 2'd2) mask_e = wd & 32'h0000_FB00;
        @(negedge clk);
        idle();
        check_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        rst = 1;
        don_e = 0; rxt_e = 0; txt_e = 0; tthr = 4; rthr = 3; mask_e = '0;
        repeat (3) @(negedge clk);
        reg_addr = 2'd1; #0.2;
        chk("R1 event reset value (in reset)", reg_rdata, 32'h0000_8100);
        rst = 0;
        @(negedge clk);
        reg_addr = 2'd1; #0.2;
        chk("R1 event reset value", reg_rdata, 32'h0000_8100);
        chk("R1 irq low", 32'(irq), 32'h0);
        reg_addr = 2'd0; #0.2;
        chk("R1/R9 mode default", reg_rdata, 32'h0000_0403);
        reg_addr = 2'd2; #0.2;
        chk("R1 mask zero", reg_rdata, 32'h0);
        check_all();

        // R8: enable all flags in mask
        cycle(0,0,0, 0,0,0,0, 0, 1,2'd2,32'hFFFF_FFFF);
        // R10: fill tx queue with 9 word pushes (last one ignored)
        for (int i = 0; i < 9; i++)
            cycle(1, 32'hA0B0C0D0 + 32'(i), 0, 0,0,0,0, 0, 0,2'd1,0);
        // R12: push 33 receive bytes (last ignored)
        for (int i = 0; i < 33; i++)
            cycle(0,0,0, 1, 8'(i*7+1), 0,0, 0, 0,2'd1,0);
        // R6: drain tx queue completely, then pop on empty
        for (int i = 0; i < 34; i++)
            cycle(0,0,1, 0,0,0,0, 0, 0,2'd1,0);
        // R11: drain with words; then byte pops down to empty and beyond
        for (int i = 0; i < 7; i++)
            cycle(0,0,0, 0,0,1,0, 0, 0,2'd1,0);
        cycle(0,0,0, 0,0,1,0, 0, 0,2'd1,0); // 4 left: word pop
        cycle(0,0,0, 1,8'h55,0,0, 0, 0,2'd1,0);
        cycle(0,0,0, 1,8'h66,0,0, 0, 0,2'd1,0);
        cycle(0,0,0, 0,0,1,0, 0, 0,2'd1,0); // R11 ignored: only 2 held
        for (int i = 0; i < 3; i++)
            cycle(0,0,0, 0,0,0,1, 0, 0,2'd1,0); // R12 last one on empty
        // R4 / R7: done pulse, clear collides with set, then clear
        cycle(0,0,0, 0,0,0,0, 1, 0,2'd1,0);
        cycle(0,0,0, 0,0,0,0, 1, 1,2'd1,32'h0000_4000);
        cycle(0,0,0, 0,0,0,0, 0, 1,2'd1,32'h0000_2800); // clear others only
        cycle(0,0,0, 0,0,0,0, 0, 1,2'd1,32'hFFFF_FFFF); // clear all
        // R9: new thresholds
        cycle(0,0,0, 0,0,0,0, 0, 1,2'd0,32'hFFFF_0A05);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit fill;
            logic [31:0] wd;
            logic [1:0]  a;
            bit we;
            fill = ((i / 150) % 2) == 0;
            we = ($urandom % 12) == 0;
            a  = 2'($urandom % 4);
            wd = $urandom;
            if (a == 2'd0) wd = {$urandom} % 33 << 8 | {$urandom} % 33;
            cycle(fill ? ($urandom % 3 == 0) : ($urandom % 9 == 0), $urandom,
                  fill ? ($urandom % 4 == 0) : ($urandom % 2 == 0),
                  fill ? ($urandom % 2 == 0) : ($urandom % 6 == 0), 8'($urandom),
                  fill ? ($urandom % 10 == 0) : ($urandom % 4 == 0),
                  ($urandom % 4 == 0),
                  ($urandom % 20 == 0), we, a, wd);
        end

        done_run = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule